// File: doc/BRIEF.md
# Fractional-Rate Tunable Time Counter

This block keeps a 64-bit time value whose rate is set by a host-programmed addend. On every reference clock cycle the registered addend is summed into a fractional accumulator. Only when that sum overflows does the time value advance, and it advances by exactly one. The mean rate of the time value is therefore addend divided by two to the accumulator width, times the reference frequency. With a 32-bit accumulator the rate can be trimmed in steps well below one part per billion.

The host writes the addend. It sets the time by writing a high word, which is only staged, and then a low word, which loads both words at once and clears the accumulator. It reads the time through a strobe that captures both halves together into a snapshot pair, so the two words of a read always belong to the same instant. The live time value is also driven out every cycle for timestamping and event logic.

Top module: `frac_time_counter`

## Requirements
- R1: After reset the time output, the accumulator, both snapshot outputs and the staged high word are zero, and the addend holds INIT_ADDEND (default zero).
- R2: In every cycle without a low-word write, the accumulator becomes (accumulator + addend) modulo 2^ACC_W at the clock edge. The time output rises by exactly one at that same edge when the sum overflows, and is otherwise unchanged. With addend 0x4000_0000, 400 cycles after a load give exactly 100 increments.
- R3: A value presented with `addend_wr` is held in the addend register from the edge that samples it. The first accumulation that uses the new value is at the following edge.
- R4: While the addend is zero, the time output does not change, except through a low-word write.
- R5: A `time_hi_wr` only stages `time_wdata` as the next high word. It leaves the time output unchanged.
- R6: A `time_lo_wr` loads the time with {staged high word, `time_wdata`} and clears the accumulator at the same edge. An overflow in that cycle is discarded. If both write strobes fall in one cycle, the load uses the previously staged high word and the new word is then staged.
- R7: A `rd_lo` strobe captures bits [31:0] of the time into `snap_lo` and bits [63:32] into `snap_hi` at the same edge, using the value present before that edge. Both outputs hold until the next strobe.
- R8: A time of all ones that is incremented becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addend_wr | input | 1 | Addend write strobe |
| addend_in | input | 32 | New addend value |
| time_hi_wr | input | 1 | Stage high word of a time load |
| time_lo_wr | input | 1 | Load time from staged high word and low word |
| time_wdata | input | 32 | Word data for time writes |
| rd_lo | input | 1 | Capture both halves of the time into the snapshot |
| snap_lo | output | 32 | Captured low word |
| snap_hi | output | 32 | Captured high word |
| time_now | output | 64 | Live time value |

## Verification
Two events can coincide: a low-word time load and an accumulator overflow that would advance the time. Likewise a snapshot strobe can fall on the same edge as an increment. Both collisions are provoked by placing the load or strobe on the exact cycle where a half-scale addend overflows, as well as by random mixes of writes, loads and reads under a fixed seed. They are judged against a cycle-level reference model in the bench. The model gives the load priority and discards the carry, and it expects the snapshot to hold the pre-edge time. Exact carry counts over fixed intervals and an all-ones wrap are checked directly.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
   // Structure of the time increment: one wide adder, or two word halves
   // where the upper half steps on the lower half reaching all ones.
   typedef enum logic {INC_FLAT = 1'b0, INC_SPLIT = 1'b1} ftc_inc_e;

   localparam int unsigned FTC_TIME_W = 64;
   localparam int unsigned FTC_WORD_W = 32;
   localparam int unsigned FTC_ACC_W  = 32;
endpackage

// File: rtl/ftc_accum.sv
module ftc_accum #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [ACC_W-1:0] addend,
   output logic [ACC_W-1:0] acc_q,
   output logic             carry
);
   logic [ACC_W:0] sum;

   always_comb begin
      sum   = {1'b0, acc_q} + {1'b0, addend};
      carry = sum[ACC_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else            acc_q <= sum[ACC_W-1:0];
   end
endmodule

// File: rtl/ftc_counter.sv
module ftc_counter
   import ftc_pkg::*;
#(
   parameter int unsigned TIME_W = 64,
   parameter int unsigned WORD_W = 32,
   parameter ftc_inc_e    INC_STYLE = INC_SPLIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   input  logic              inc,
   output logic [TIME_W-1:0] time_q
);
   localparam int unsigned HI_W = TIME_W - WORD_W;

   logic [TIME_W-1:0] time_inc;

   generate
      if (INC_STYLE == INC_SPLIT) begin : g_split
         logic [WORD_W-1:0] lo_part;
         logic [HI_W-1:0]   hi_part;
         logic              lo_full;
         always_comb begin
            lo_part  = time_q[WORD_W-1:0];
            hi_part  = time_q[TIME_W-1:WORD_W];
            lo_full  = &lo_part;
            time_inc = {hi_part + {{(HI_W-1){1'b0}}, lo_full},
                        lo_part + {{(WORD_W-1){1'b0}}, 1'b1}};
         end
      end else begin : g_flat
         always_comb time_inc = time_q + {{(TIME_W-1){1'b0}}, 1'b1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    time_q <= '0;
      else if (load) time_q <= load_val;
      else if (inc)  time_q <= time_inc;
   end
endmodule

// File: rtl/ftc_snapshot.sv
module ftc_snapshot #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned HI_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [WORD_W-1:0] lo_in,
   input  logic [HI_W-1:0]   hi_in,
   output logic [WORD_W-1:0] lo_q,
   output logic [HI_W-1:0]   hi_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (capture) begin
         lo_q <= lo_in;
         hi_q <= hi_in;
      end
   end
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter
   import ftc_pkg::*;
#(
   parameter int unsigned TIME_W      = FTC_TIME_W,
   parameter int unsigned WORD_W      = FTC_WORD_W,
   parameter int unsigned ACC_W       = FTC_ACC_W,
   parameter logic [31:0] INIT_ADDEND = 32'h0,
   parameter ftc_inc_e    INC_STYLE   = INC_SPLIT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     addend_wr,
   input  logic [ACC_W-1:0]         addend_in,
   input  logic                     time_hi_wr,
   input  logic                     time_lo_wr,
   input  logic [WORD_W-1:0]        time_wdata,
   input  logic                     rd_lo,
   output logic [WORD_W-1:0]        snap_lo,
   output logic [TIME_W-WORD_W-1:0] snap_hi,
   output logic [TIME_W-1:0]        time_now
);
   localparam int unsigned HI_W = TIME_W - WORD_W;

   // Elaboration-time parameter checks
   if (TIME_W != 2 * WORD_W) begin : g_bad_time_w
      $error("TIME_W must be twice WORD_W");
   end
   if (ACC_W < 2 || ACC_W > 32) begin : g_bad_acc_w
      $error("ACC_W must lie between 2 and 32");
   end
   if (WORD_W < 2) begin : g_bad_word_w
      $error("WORD_W must be at least 2");
   end

   logic [ACC_W-1:0] addend_q;
   logic [ACC_W-1:0] acc_q;
   logic [HI_W-1:0]  stage_hi;
   logic             carry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addend_q <= INIT_ADDEND[ACC_W-1:0];
      else if (addend_wr) addend_q <= addend_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stage_hi <= '0;
      else if (time_hi_wr) stage_hi <= time_wdata;
   end

   ftc_accum #(.ACC_W(ACC_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (time_lo_wr),
      .addend (addend_q),
      .acc_q  (acc_q),
      .carry  (carry)
   );

   ftc_counter #(.TIME_W(TIME_W), .WORD_W(WORD_W), .INC_STYLE(INC_STYLE)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (time_lo_wr),
      .load_val ({stage_hi, time_wdata}),
      .inc      (carry),
      .time_q   (time_now)
   );

   ftc_snapshot #(.WORD_W(WORD_W), .HI_W(HI_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rd_lo),
      .lo_in   (time_now[WORD_W-1:0]),
      .hi_in   (time_now[TIME_W-1:WORD_W]),
      .lo_q    (snap_lo),
      .hi_q    (snap_hi)
   );
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
   parameter int unsigned TIME_W = 64,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ACC_W  = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     addend_wr,
   input logic [ACC_W-1:0]         addend_in,
   input logic                     time_hi_wr,
   input logic                     time_lo_wr,
   input logic [WORD_W-1:0]        time_wdata,
   input logic                     rd_lo,
   input logic [WORD_W-1:0]        snap_lo,
   input logic [TIME_W-WORD_W-1:0] snap_hi,
   input logic [TIME_W-1:0]        time_now,
   input logic [ACC_W-1:0]         addend_q,
   input logic [ACC_W-1:0]         acc_q,
   input logic [TIME_W-WORD_W-1:0] stage_hi
);
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !time_lo_wr |=> (time_now == $past(time_now)) ||
                      (time_now == $past(time_now) + 1'b1));

   assert_acc_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !time_lo_wr |=> acc_q == $past(acc_q) + $past(addend_q));

   assert_addend_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addend_wr |=> addend_q == $past(addend_in));

   assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (addend_q == '0 && !time_lo_wr) |=> $stable(time_now));

   assert_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
      time_hi_wr |=> stage_hi == $past(time_wdata));

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      time_lo_wr |=> (time_now == {$past(stage_hi), $past(time_wdata)}) && (acc_q == '0));

   assert_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> {snap_hi, snap_lo} == $past(time_now));

   assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> $stable(snap_lo) && $stable(snap_hi));

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (time_now == '1 && !time_lo_wr) |=> (time_now == '0) || (time_now == '1));
endmodule

bind frac_time_counter ftc_checker #(
   .TIME_W(TIME_W), .WORD_W(WORD_W), .ACC_W(ACC_W)
) u_ftc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .addend_wr  (addend_wr),
   .addend_in  (addend_in),
   .time_hi_wr (time_hi_wr),
   .time_lo_wr (time_lo_wr),
   .time_wdata (time_wdata),
   .rd_lo      (rd_lo),
   .snap_lo    (snap_lo),
   .snap_hi    (snap_hi),
   .time_now   (time_now),
   .addend_q   (addend_q),
   .acc_q      (acc_q),
   .stage_hi   (stage_hi)
);

// File: tb/frac_time_counter_bench.sv
`timescale 1ns/1ps
module frac_time_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addend_wr = 1'b0;
   logic [31:0] addend_in = '0;
   logic        time_hi_wr = 1'b0;
   logic        time_lo_wr = 1'b0;
   logic [31:0] time_wdata = '0;
   logic        rd_lo = 1'b0;
   logic [31:0] snap_lo;
   logic [31:0] snap_hi;
   logic [63:0] time_now;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string cur_req = "R1";

   // reference model state
   logic [31:0] m_acc, m_add, m_stage, m_slo, m_shi;
   logic [63:0] m_time;

   always #2 clk = ~clk;

   frac_time_counter u_frac_time_counter (
      .clk(clk), .rst_n(rst_n), .addend_wr(addend_wr), .addend_in(addend_in),
      .time_hi_wr(time_hi_wr), .time_lo_wr(time_lo_wr), .time_wdata(time_wdata),
      .rd_lo(rd_lo), .snap_lo(snap_lo), .snap_hi(snap_hi), .time_now(time_now)
   );

   function automatic logic [32:0] acc_sum(input logic [31:0] a, input logic [31:0] b);
      return {1'b0, a} + {1'b0, b};
   endfunction

   always @(posedge clk) begin
      logic [32:0] s;
      if (!rst_n) begin
         m_acc = '0; m_add = '0; m_stage = '0; m_slo = '0; m_shi = '0; m_time = '0;
      end else begin
         if (rd_lo) begin
            m_slo = m_time[31:0];
            m_shi = m_time[63:32];
         end
         if (time_lo_wr) begin
            m_time = {m_stage, time_wdata};
            m_acc  = '0;
         end else begin
            s = acc_sum(m_acc, m_add);
            m_acc = s[31:0];
            if (s[32]) m_time = m_time + 64'd1;
         end
         if (time_hi_wr) m_stage = time_wdata;
         if (addend_wr)  m_add = addend_in;
      end
   end

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // sample at falling edge, compare with model, then clear strobes
   task automatic tick();
      @(negedge clk);
      check64(cur_req, time_now, m_time);
      check64("R7", {snap_hi, snap_lo}, {m_shi, m_slo});
      addend_wr = 1'b0; time_hi_wr = 1'b0; time_lo_wr = 1'b0; rd_lo = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic set_addend(input logic [31:0] v);
      addend_in = v; addend_wr = 1'b1; tick();
   endtask

   task automatic load_time(input logic [63:0] v);
      time_wdata = v[63:32]; time_hi_wr = 1'b1; tick();
      time_wdata = v[31:0];  time_lo_wr = 1'b1; tick();
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual running expected finished");
      finish_up();
   end

   initial begin
      logic [63:0] t0;
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cur_req = "R1";
      @(negedge clk);
      check64("R1", time_now, 64'd0);
      check64("R1", {snap_hi, snap_lo}, 64'd0);
      // R4: addend zero from reset, time frozen
      cur_req = "R4";
      run(50);
      check64("R4", time_now, 64'd0);
      // R3: new addend used from the edge after the write
      cur_req = "R3";
      set_addend(32'h8000_0000);
      check64("R3", time_now, 64'd0);
      tick();
      check64("R3", time_now, 64'd0);
      tick();
      check64("R3", time_now, 64'd1);
      // R2: exact rate, 400 cycles at quarter scale give 100 steps
      cur_req = "R2";
      set_addend(32'h4000_0000);
      load_time(64'h0000_0000_0000_0000);
      run(400);
      check64("R2", time_now, 64'd100);
      // R5: staging high word leaves time unchanged
      cur_req = "R5";
      set_addend(32'h0);
      tick();
      t0 = time_now;
      time_wdata = 32'hDEAD_BEEF; time_hi_wr = 1'b1; tick();
      run(3);
      check64("R5", time_now, t0);
      // R6: load coinciding with a carry; carry discarded
      cur_req = "R6";
      set_addend(32'h8000_0000);
      tick();
      time_wdata = 32'h0000_0010; time_lo_wr = 1'b1; tick();
      check64("R6", time_now, 64'hDEAD_BEEF_0000_0010);
      tick();
      check64("R6", time_now, 64'hDEAD_BEEF_0000_0010);
      tick();
      check64("R6", time_now, 64'hDEAD_BEEF_0000_0011);
      // R7: snapshot on an incrementing edge holds pre-edge value
      cur_req = "R7";
      tick();
      rd_lo = 1'b1; tick();
      check64("R7", {snap_hi, snap_lo}, 64'hDEAD_BEEF_0000_0011);
      tick();
      check64("R7", {snap_hi, snap_lo}, 64'hDEAD_BEEF_0000_0011);
      // R8: wrap from all ones
      cur_req = "R8";
      set_addend(32'hFFFF_FFFF);
      load_time(64'hFFFF_FFFF_FFFF_FFFF);
      tick();
      check64("R8", time_now, 64'hFFFF_FFFF_FFFF_FFFF);
      tick();
      check64("R8", time_now, 64'd0);
      // low-word carry into high word
      load_time(64'h0000_0001_FFFF_FFFF);
      run(2);
      check64("R2", time_now, 64'h0000_0002_0000_0000);
      // random mix against the model
      cur_req = "R2";
      for (int i = 0; i < 20000; i++) begin
         int unsigned r;
         r = $urandom % 100;
         if (r < 4) begin
            addend_in = ($urandom % 4 == 0) ? 32'h0 : $urandom;
            addend_wr = 1'b1;
         end
         if (r >= 10 && r < 13) begin
            time_wdata = ($urandom % 2 == 0) ? 32'hFFFF_FFFF : $urandom;
            time_hi_wr = 1'b1;
         end
         if (r >= 20 && r < 22) begin
            time_wdata = ($urandom % 2 == 0) ? 32'hFFFF_FFFE : $urandom;
            time_lo_wr = 1'b1;
            if ($urandom % 4 == 0) time_hi_wr = 1'b1;
         end
         if (r >= 40 && r < 50) rd_lo = 1'b1;
         tick();
      end
      finish_up();
   end
endmodule